// File: doc/BRIEF.md
# Output Clock Gating and Power-Down Controller

This block sits between a set of divided source clocks and their output drivers. For every output lane it decides on each cycle whether the lane follows its source, holds a steady low, or floats. It makes that decision from a per-lane enable bit, a per-lane stoppable attribute on the stop-capable lanes, an active-low global stop request, drive-or-float choices for the stopped and powered-down states, and an asynchronous power-down input. The configuration arrives as register fields from a neighbouring register block. The source clocks are sampled on `clk`, which is the reference clock.

The lanes are laid out in a fixed order in every lane vector. Lanes `0..N_SRC-1` are the stop-capable differential lanes. The next `N_CPU` lanes are processor pairs. Lane `N_SRC+N_CPU` is the display pair. The top `N_FREE` lanes are free-running single-ended lanes. Each lane has a true output, a complement output and an output-enable (1 = driven, 0 = high impedance).

A lane can only start or stop while its source is low, so no shortened pulse reaches a driver. After power-down is released, and after reset, the lanes wait a settle count of reference cycles before they may run. A one-way test mode, entered from a pin level captured just after reset or from a register write, overrides everything else. In test mode every lane either floats or carries the reference divided by `REF_DIV`. Only a reset leaves test mode.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: Outside test and power-down, once settled, an enabled lane that is not halted drives `out_t` equal to its source, and a lane with its enable bit at 0 drives `out_t` low with `out_oe`=1.
- R2: While `stop_n`=0, each stop-capable lane whose `src_stoppable` bit is 1 is halted (`out_t` low). Stop-capable lanes with the bit at 0, the processor lanes, the display lane and the free-running lanes keep running.
- R3: A lane halted by the stop request has `out_oe`=1 when `stop_hiz`=0 and `out_oe`=0 when `stop_hiz`=1, whatever its enable bit. Outside test and power-down, no other condition gives `out_oe`=0.
- R4: A lane's run state changes only at a `clk` edge where its source is low. A lane running when its source rises keeps the whole high phase even if it is disabled or stopped during that phase, and a lane enabled during a high phase stays low until the next rising source edge. Outside test mode, `out_t` never rises unless its source rises.
- R5: `pd`=1 forces every `out_t` low at once, with no clock edge needed, and keeps it low. `out_oe` is then `~src_pd_hiz` on the stop-capable lanes, `~cpu_pd_hiz[j]` on processor lane j, `~dot_pd_hiz` on the display lane, and 1 on the free-running lanes.
- R6: After `pd` falls, a lane whose source stays low may first run at the (SETTLE+1)-th rising `clk` edge that follows. At the SETTLE-th edge it is still held low. The same wait applies after reset.
- R7: Test mode is entered when `test_sel_pin` is 1 at the first rising `clk` edge after reset release, or when `test_enter` is 1 at any rising edge. It then persists, whatever those inputs do, until `rst_n` is asserted.
- R8: In test mode `pd`, enables and stop request have no effect. All lanes float (`out_oe`=0, `out_t`=0) when the selector is 0, or all drive the divided reference (`out_oe`=1) when it is 1. The selector is `test_refn` if the register path was used, and otherwise the live `test_mode_pin`.
- R9: The divided reference is high for REF_DIV/2 `clk` cycles and low for REF_DIV/2, with a period of REF_DIV cycles.
- R10: `out_c` is always the inverse of `out_t`, so a driven halted lane holds true low and complement high.
- R11: During reset, with the stop request inactive, every lane has `out_t`=0, `out_c`=1 and `out_oe`=1, and test mode is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| pd | input | 1 | Asynchronous active-high power-down |
| src_clk | input | NL | Divided source clock per lane |
| lane_en | input | NL | Per-lane enable (register resets to all 1) |
| src_stoppable | input | N_SRC | 1 = stop-capable lane obeys the stop request (resets to 0) |
| stop_n | input | 1 | Active-low global stop request (resets to 1) |
| stop_hiz | input | 1 | Stopped-lane look: 0 driven low, 1 floating |
| src_pd_hiz | input | 1 | Power-down look of the stop-capable lanes |
| cpu_pd_hiz | input | N_CPU | Power-down look per processor lane |
| dot_pd_hiz | input | 1 | Power-down look of the display lane (resets to 1) |
| test_sel_pin | input | 1 | Test-select level captured after reset |
| test_mode_pin | input | 1 | Live float/divided choice for pin-entered test |
| test_enter | input | 1 | Register request to enter test mode |
| test_refn | input | 1 | Float (0) / divided (1) choice for register-entered test |
| out_t | output | NL | True output per lane |
| out_c | output | NL | Complement output per lane |
| out_oe | output | NL | Output enable per lane, 0 = high impedance |

## Verification
The bench builds the block with two stop-capable lanes, two processor lanes, one display lane and one free-running lane, with REF_DIV=4 and SETTLE=3. With six lanes, every combination of enables, stoppable bits, stop request and stop look fits in 1024 configurations, and the bench sweeps all of them. Every combination of the four power-down look bits is also swept. The short settle count lets the bench hit both edges of the wake-up boundary on each power-down cycle. The short divider lets it check the test-mode waveform over whole periods in a few cycles.

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter int N_SRC   = 7,
  parameter int N_CPU   = 2,
  parameter int N_FREE  = 3,
  parameter int REF_DIV = 8,
  parameter int SETTLE  = 16,
  localparam int NL  = N_SRC + N_CPU + 1 + N_FREE,
  localparam int DOT = N_SRC + N_CPU,
  localparam int CW  = $clog2(SETTLE + 1),
  localparam int RW  = $clog2(REF_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic [NL-1:0]    src_clk,
  input  logic [NL-1:0]    lane_en,
  input  logic [N_SRC-1:0] src_stoppable,
  input  logic             stop_n,
  input  logic             stop_hiz,
  input  logic             src_pd_hiz,
  input  logic [N_CPU-1:0] cpu_pd_hiz,
  input  logic             dot_pd_hiz,
  input  logic             test_sel_pin,
  input  logic             test_mode_pin,
  input  logic             test_enter,
  input  logic             test_refn,
  output logic [NL-1:0]    out_t,
  output logic [NL-1:0]    out_c,
  output logic [NL-1:0]    out_oe
);

  logic [CW-1:0] wake_cnt;
  logic [RW-1:0] rcnt;
  logic [NL-1:0] run, want, stop_hit, pd_oe;
  logic          booted, test_hw, test_sw;

  wire awake       = (wake_cnt == CW'(SETTLE));
  wire test_active = test_hw | test_sw;
  wire refn_sel    = test_sw ? test_refn : test_mode_pin;
  wire ref_div     = (rcnt < RW'(REF_DIV / 2));

  always_comb begin
    stop_hit = '0;
    stop_hit[N_SRC-1:0] = src_stoppable & {N_SRC{~stop_n}};
    pd_oe = '1;
    pd_oe[N_SRC-1:0] = {N_SRC{~src_pd_hiz}};
    pd_oe[DOT-1:N_SRC] = ~cpu_pd_hiz;
    pd_oe[DOT] = ~dot_pd_hiz;
  end

  assign want = lane_en & ~stop_hit & {NL{awake}};

  always_ff @(posedge clk or negedge rst_n or posedge pd) begin
    if (!rst_n) begin
      wake_cnt <= '0;
      run      <= '0;
    end else if (pd) begin
      wake_cnt <= '0;
      run      <= '0;
    end else begin
      if (!awake) wake_cnt <= wake_cnt + CW'(1);
      run <= (run & src_clk) | (want & ~src_clk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt    <= '0;
      booted  <= 1'b0;
      test_hw <= 1'b0;
      test_sw <= 1'b0;
    end else begin
      rcnt   <= (rcnt == RW'(REF_DIV - 1)) ? '0 : rcnt + RW'(1);
      booted <= 1'b1;
      if (!booted && test_sel_pin) test_hw <= 1'b1;
      if (test_enter) test_sw <= 1'b1;
    end
  end

  always_comb begin
    if (test_active) begin
      out_t  = refn_sel ? {NL{ref_div}} : '0;
      out_oe = {NL{refn_sel}};
    end else if (pd) begin
      out_t  = '0;
      out_oe = pd_oe;
    end else begin
      out_t  = run & src_clk;
      out_oe = ~(stop_hit & ~run & {NL{stop_hiz}});
    end
  end

  assign out_c = ~out_t;

  for (genvar i = 0; i < NL; i++) begin : g_chk
    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n || test_active)
      $rose(out_t[i]) |-> $rose(src_clk[i])); // R4
  end

  AST_PD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && !test_active) |-> (out_t == '0)); // R5

  AST_SETTLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pd) && !test_active) |-> (out_t == '0)); // R6

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |=> test_active); // R7

  AST_FLOAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_active && !pd && (out_oe != '1)) |-> (stop_hiz && !stop_n)); // R3

endmodule

// File: tb/clkout_gate_ctrl_tb.sv
module clkout_gate_ctrl_tb;
  localparam int NS = 2, NC = 2, NF = 1, RD = 4, SET = 3;
  localparam int NL = NS + NC + 1 + NF;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pd = 1'b0;
  logic [NL-1:0] src_clk = '0, lane_en = '1;
  logic [NS-1:0] src_stoppable = '0;
  logic stop_n = 1'b1, stop_hiz = 1'b0, src_pd_hiz = 1'b0, dot_pd_hiz = 1'b1;
  logic [NC-1:0] cpu_pd_hiz = '0;
  logic test_sel_pin = 1'b0, test_mode_pin = 1'b0, test_enter = 1'b0, test_refn = 1'b0;
  logic [NL-1:0] out_t, out_c, out_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkout_gate_ctrl #(.N_SRC(NS), .N_CPU(NC), .N_FREE(NF), .REF_DIV(RD), .SETTLE(SET)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd(pd), .src_clk(src_clk), .lane_en(lane_en),
    .src_stoppable(src_stoppable), .stop_n(stop_n), .stop_hiz(stop_hiz),
    .src_pd_hiz(src_pd_hiz), .cpu_pd_hiz(cpu_pd_hiz), .dot_pd_hiz(dot_pd_hiz),
    .test_sel_pin(test_sel_pin), .test_mode_pin(test_mode_pin), .test_enter(test_enter),
    .test_refn(test_refn), .out_t(out_t), .out_c(out_c), .out_oe(out_oe));

  task automatic chk(input string tag, input logic [NL-1:0] got, input logic [NL-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    src_clk = {NL{v}};
    #2;
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0;
    test_sel_pin = sel;
    test_enter = 1'b0;
    #5;
    chk("R11 reset t", out_t, '0);
    chk("R11 reset c", out_c, '1);
    chk("R11 reset oe", out_oe, '1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_sel_pin = 1'b0;
    repeat (SET + 3) step(1'b0);
  endtask

  task automatic refn_check(input string tag);
    logic [4*RD-1:0] s;
    int bad = 0;
    for (int k = 0; k < 4 * RD; k++) begin
      @(posedge clk);
      #5;
      s[k] = out_t[0];
      if (out_t != {NL{out_t[0]}} || out_c != ~out_t) bad++;
    end
    chk_int({tag, " R9 lanes equal"}, bad, 0);
    chk_int({tag, " R9 high count"}, $countones(s), 2 * RD);
    bad = 0;
    for (int k = 0; k < 3 * RD; k++) begin
      if (s[k] != s[k + RD]) bad++;
      if (s[k] == s[k + RD / 2]) bad++;
    end
    chk_int({tag, " R9 period"}, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);

    // R1 R2 R3 R10: full configuration sweep
    for (int cfg = 0; cfg < 1024; cfg++) begin
      logic [NL-1:0] et, eo;
      lane_en = cfg[5:0];
      src_stoppable = cfg[7:6];
      stop_n = cfg[8];
      stop_hiz = cfg[9];
      step(1'b0);
      step(1'b1);
      for (int i = 0; i < NL; i++) begin
        logic hit;
        hit = (i < NS) && src_stoppable[i] && !stop_n;
        et[i] = lane_en[i] && !hit;
        eo[i] = !(hit && stop_hiz);
      end
      chk("R1 R2 sweep t", out_t, et);
      chk("R10 sweep c", out_c, ~et);
      chk("R3 sweep oe", out_oe, eo);
    end

    lane_en = '1; src_stoppable = '0; stop_n = 1'b1; stop_hiz = 1'b0;
    step(1'b0); step(1'b1);
    chk("R1 all run", out_t, '1);

    // R4: changes during a high phase wait for the low phase
    lane_en = '0;
    @(posedge clk); #5;
    chk("R4 keep high phase", out_t, '1);
    step(1'b0); step(1'b1);
    chk("R1 disabled low", out_t, '0);
    chk("R1 disabled driven", out_oe, '1);
    lane_en = '1;
    @(posedge clk); #5;
    chk("R4 no late start", out_t, '0);
    step(1'b0); step(1'b1);
    chk("R4 restart", out_t, '1);
    src_stoppable = 2'b01; stop_hiz = 1'b1; stop_n = 1'b0;
    @(posedge clk); #5;
    chk("R4 stop waits t", out_t, '1);
    chk("R4 stop waits oe", out_oe, '1);
    step(1'b0); step(1'b1);
    chk("R2 stopped t", out_t, 6'b111110);
    chk("R3 stopped float", out_oe, 6'b111110);
    stop_n = 1'b1; src_stoppable = '0; stop_hiz = 1'b0;
    step(1'b0); step(1'b1);
    chk("R2 resumed", out_t, '1);

    // R5 R6: power-down look sweep and settle boundary
    for (int m = 0; m < 16; m++) begin
      src_pd_hiz = m[0];
      cpu_pd_hiz = m[2:1];
      dot_pd_hiz = m[3];
      pd = 1'b1;
      #1;
      chk("R5 async low", out_t, '0);
      chk("R5 pd look", out_oe, {1'b1, ~dot_pd_hiz, ~cpu_pd_hiz, {NS{~src_pd_hiz}}});
      step(1'b0); step(1'b1);
      chk("R5 held low", out_t, '0);
      step(1'b0);
      pd = 1'b0;
      if (m[0]) begin
        repeat (SET) step(1'b0);
        step(1'b1);
        chk("R6 wake at SETTLE+1", out_t, '1);
      end else begin
        repeat (SET - 1) step(1'b0);
        step(1'b1);
        chk("R6 still settling", out_t, '0);
        step(1'b0); step(1'b1);
        chk("R6 woke", out_t, '1);
      end
    end

    // R7 R8 R9: register-entered test mode
    @(negedge clk);
    test_refn = 1'b0;
    test_enter = 1'b1;
    @(negedge clk);
    test_enter = 1'b0;
    step(1'b1);
    chk("R8 sw hiz oe", out_oe, '0);
    chk("R8 sw hiz t", out_t, '0);
    test_mode_pin = 1'b1;
    pd = 1'b1;
    step(1'b0); step(1'b1);
    chk("R7 R8 pin ignored sticky", out_oe, '0);
    test_refn = 1'b1;
    step(1'b0);
    chk("R8 sw refn oe", out_oe, '1);
    refn_check("sw");
    pd = 1'b0; test_mode_pin = 1'b0; test_refn = 1'b0;
    do_reset(1'b0);
    step(1'b1);
    chk("R7 reset clears test oe", out_oe, '1);
    chk("R7 reset clears test t", out_t, '1);

    // R7 R8: pin-entered test mode
    do_reset(1'b1);
    test_mode_pin = 1'b0;
    step(1'b1);
    chk("R7 hw hiz oe", out_oe, '0);
    test_mode_pin = 1'b1;
    test_refn = 1'b0;
    step(1'b0);
    chk("R8 hw refn oe", out_oe, '1);
    refn_check("hw");
    test_mode_pin = 1'b0;
    step(1'b0);
    chk("R8 hw live pin", out_oe, '0);
    do_reset(1'b0);
    step(1'b1);
    chk("R7 normal after reset", out_t, '1);
    chk("R7 normal after reset oe", out_oe, '1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule